// File: doc/BRIEF.md
# Single and Double Shock Detector

This block inspects every raw three-axis acceleration sample at the full sensor rate and reports mechanical shocks. A shock is a short excursion of at least one enabled axis beyond a programmable magnitude that returns below it within a programmable number of samples. A double shock is a second such excursion that begins inside a window opening a programmable number of samples after the first one ends.

Each detected event produces a one-cycle pulse and sets a sticky flag that stays high until a clear strobe. A status field records which axes were over the threshold on the sample that opened the reported shock. A pending double shock is abandoned in three cases: any over-threshold sample during the quiet gap while suppression is on, an over-threshold sample on the last sample of the gap, or a second excursion that lasts too long.

Top module: `shock_detect`

## Requirements
- R1: An axis is over threshold on a sample when its axis enable bit is set (bit 0 = X, bit 1 = Y, bit 2 = Z) and the magnitude of its two's-complement value is strictly greater than the unsigned threshold; the most negative value counts at its full magnitude.
- R2: A first shock qualifies when between 1 and durLen consecutive valid samples are over threshold and the next valid sample is not. singlePulse rises in the cycle after the edge that takes that ending sample. A longer excursion, or any excursion when durLen is 0, is not a shock.
- R3: When double detection is armed, the gap counts latLen valid samples after the ending sample. The window then counts winLen valid samples. A second excursion whose first over-threshold sample lands in the window and that qualifies under the R2 rule pulses doublePulse in the cycle after its ending sample. If the window expires with no excursion, the detector returns to idle.
- R4: With suppressEn set, any over-threshold sample during the gap abandons the pending double shock, and the detector returns to idle.
- R5: An over-threshold sample on the final sample of the gap abandons the pending double shock, whatever the value of suppressEn.
- R6: A second excursion longer than durLen samples abandons the pending double shock and produces no event.
- R7: Double detection is armed only when doubleEn is set and both latLen and winLen are nonzero. Otherwise every qualified excursion is treated as a first shock.
- R8: singleEn gates the single event (its pulse, flag and status update), and doubleEn gates the double event. A first shock still arms the double search when singleEn is low.
- R9: On each reported event, firstAxis (bit 0 = X, bit 1 = Y, bit 2 = Z) takes the over-threshold axes of the sample that opened that event's excursion. It is never cleared, and it keeps its value between events.
- R10: singleFlag and doubleFlag set with their pulse and hold until clearStrobe is seen on a clock edge. A set on the same edge as the clear wins.
- R11: Cycles with sampleValid low change no detector state and are not counted.
- R12: Each event pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Marks a new sample on the accel inputs |
| accelX | input | SAMPLE_W | Signed X sample |
| accelY | input | SAMPLE_W | Signed Y sample |
| accelZ | input | SAMPLE_W | Signed Z sample |
| threshold | input | SAMPLE_W | Unsigned magnitude threshold |
| durLen | input | CNT_W | Longest excursion, in samples |
| latLen | input | CNT_W | Gap length, in samples |
| winLen | input | CNT_W | Second-shock window length, in samples |
| axisEn | input | 3 | Per-axis participation enables |
| suppressEn | input | 1 | Abandon the double shock on any spike during the gap |
| singleEn | input | 1 | Single event enable |
| doubleEn | input | 1 | Double event enable |
| clearStrobe | input | 1 | Clears both sticky flags |
| singlePulse | output | 1 | One-cycle single-shock event |
| doublePulse | output | 1 | One-cycle double-shock event |
| singleFlag | output | 1 | Sticky single-shock flag |
| doubleFlag | output | 1 | Sticky double-shock flag |
| firstAxis | output | 3 | Axes that opened the last reported shock |

## Verification
The bench builds the block with SAMPLE_W = 12 and CNT_W = 6. The narrow sample width puts the most negative code (-2048) against the widest 12-bit threshold, which tests the magnitude rule at its edge. The counter width still allows the short timing settings used in the tests (duration 3, gap 2, window 4). These settings keep every boundary close: the excursion one sample over the limit, the gap's final sample, the window's last sample, and the zero gap that disarms double detection.

// File: rtl/shock_pkg.sv
package shock_pkg;

  localparam int NUM_AXES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPIKE1,
    ST_LATENT,
    ST_WINDOW,
    ST_SPIKE2,
    ST_HOLD
  } detState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntLoadOne;
    logic cntClear;
    logic cntInc;
    logic capFirst;
    logic capSecond;
    logic fireSingle;
    logic fireDouble;
  } ctrlStrobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic spike;
    logic cntGeDur;
    logic cntLeDur;
    logic latLast;
    logic winLast;
  } dpStatus_t;

endpackage

// File: rtl/shock_datapath.sv
module shock_datapath
  import shock_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               sampleValid,
  input  logic [NUM_AXES-1:0][SAMPLE_W-1:0]  accelVec,
  input  logic [SAMPLE_W-1:0]                threshold,
  input  logic [NUM_AXES-1:0]                axisEn,
  input  logic [CNT_W-1:0]                   durLen,
  input  logic [CNT_W-1:0]                   latLen,
  input  logic [CNT_W-1:0]                   winLen,
  input  logic                               clearStrobe,
  input  ctrlStrobe_t                        strobe,
  output dpStatus_t                          status,
  output logic                               singlePulse,
  output logic                               doublePulse,
  output logic                               singleFlag,
  output logic                               doubleFlag,
  output logic [NUM_AXES-1:0]                firstAxis
);

  logic [NUM_AXES-1:0][SAMPLE_W-1:0] magVec;
  logic [NUM_AXES-1:0]               aboveVec;
  logic [CNT_W-1:0]                  cnt;
  logic [NUM_AXES-1:0]               candFirst;
  logic [NUM_AXES-1:0]               candSecond;

  // per-axis magnitude compare
  for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
    assign magVec[g]   = accelVec[g][SAMPLE_W-1] ? ((~accelVec[g]) + 1'b1) : accelVec[g];
    assign aboveVec[g] = axisEn[g] && (magVec[g] > threshold);
  end

  assign status.spike    = sampleValid && (|aboveVec);
  assign status.cntGeDur = (cnt >= durLen);
  assign status.cntLeDur = (cnt <= durLen);
  assign status.latLast  = (({1'b0, cnt} + 1'b1) == {1'b0, latLen});
  assign status.winLast  = (({1'b0, cnt} + 1'b1) == {1'b0, winLen});

  // shared sample counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strobe.cntLoadOne) begin
      cnt <= CNT_W'(1);
    end else if (strobe.cntClear) begin
      cnt <= '0;
    end else if (strobe.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  // candidate axis capture at excursion start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      candFirst  <= '0;
      candSecond <= '0;
    end else begin
      if (strobe.capFirst)  candFirst  <= aboveVec;
      if (strobe.capSecond) candSecond <= aboveVec;
    end
  end

  // events, status and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      singlePulse <= 1'b0;
      doublePulse <= 1'b0;
      singleFlag  <= 1'b0;
      doubleFlag  <= 1'b0;
      firstAxis   <= '0;
    end else begin
      singlePulse <= strobe.fireSingle;
      doublePulse <= strobe.fireDouble;
      if (strobe.fireSingle)      singleFlag <= 1'b1;
      else if (clearStrobe)       singleFlag <= 1'b0;
      if (strobe.fireDouble)      doubleFlag <= 1'b1;
      else if (clearStrobe)       doubleFlag <= 1'b0;
      if (strobe.fireDouble)      firstAxis  <= candSecond;
      else if (strobe.fireSingle) firstAxis  <= candFirst;
    end
  end

  AST_SINGLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    singlePulse |=> !singlePulse); // R12
  AST_DOUBLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    doublePulse |=> !doublePulse); // R12
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (singlePulse |-> singleFlag) and (doublePulse |-> doubleFlag)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (singleFlag && !clearStrobe) |=> singleFlag); // R10
  AST_AXIS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(singlePulse || doublePulse) |-> $stable(firstAxis)); // R9

endmodule

// File: rtl/shock_ctrl.sv
module shock_ctrl
  import shock_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleValid,
  input  dpStatus_t        status,
  input  logic [CNT_W-1:0] latLen,
  input  logic [CNT_W-1:0] winLen,
  input  logic             suppressEn,
  input  logic             singleEn,
  input  logic             doubleEn,
  output ctrlStrobe_t      strobe
);

  detState_t state, nextState;
  logic      doubleArmed;

  assign doubleArmed = doubleEn && (latLen != '0) && (winLen != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (sampleValid) begin
      case (state)
        ST_IDLE: begin
          if (status.spike) begin
            strobe.cntLoadOne = 1'b1;
            strobe.capFirst   = 1'b1;
            nextState         = ST_SPIKE1;
          end
        end
        ST_SPIKE1: begin
          if (status.spike) begin
            if (status.cntGeDur) nextState = ST_HOLD;
            else                 strobe.cntInc = 1'b1;
          end else if (status.cntLeDur) begin
            strobe.fireSingle = singleEn;
            if (doubleArmed) begin
              strobe.cntClear = 1'b1;
              nextState       = ST_LATENT;
            end else begin
              nextState = ST_IDLE;
            end
          end else begin
            nextState = ST_IDLE;
          end
        end
        ST_LATENT: begin
          if (status.latLast && status.spike) begin
            nextState = ST_HOLD;
          end else if (status.spike && suppressEn) begin
            nextState = ST_IDLE;
          end else if (status.latLast) begin
            strobe.cntClear = 1'b1;
            nextState       = ST_WINDOW;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        ST_WINDOW: begin
          if (status.spike) begin
            strobe.cntLoadOne = 1'b1;
            strobe.capSecond  = 1'b1;
            nextState         = ST_SPIKE2;
          end else if (status.winLast) begin
            nextState = ST_IDLE;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        ST_SPIKE2: begin
          if (status.spike) begin
            if (status.cntGeDur) nextState = ST_HOLD;
            else                 strobe.cntInc = 1'b1;
          end else begin
            strobe.fireDouble = doubleEn && status.cntLeDur;
            nextState         = ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (!status.spike) nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  AST_STALL_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(state)); // R11
  AST_DOUBLE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATENT) |-> (latLen != '0 && winLen != '0)); // R7

endmodule

// File: rtl/shock_detect.sv
module shock_detect
  import shock_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] accelX,
  input  logic [SAMPLE_W-1:0] accelY,
  input  logic [SAMPLE_W-1:0] accelZ,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [CNT_W-1:0]    durLen,
  input  logic [CNT_W-1:0]    latLen,
  input  logic [CNT_W-1:0]    winLen,
  input  logic [2:0]          axisEn,
  input  logic                suppressEn,
  input  logic                singleEn,
  input  logic                doubleEn,
  input  logic                clearStrobe,
  output logic                singlePulse,
  output logic                doublePulse,
  output logic                singleFlag,
  output logic                doubleFlag,
  output logic [2:0]          firstAxis
);

  ctrlStrobe_t                       strobe;
  dpStatus_t                         status;
  logic [NUM_AXES-1:0][SAMPLE_W-1:0] accelVec;

  assign accelVec = {accelZ, accelY, accelX};

  shock_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .status     (status),
    .latLen     (latLen),
    .winLen     (winLen),
    .suppressEn (suppressEn),
    .singleEn   (singleEn),
    .doubleEn   (doubleEn),
    .strobe     (strobe)
  );

  shock_datapath #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .sampleValid(sampleValid),
    .accelVec   (accelVec),
    .threshold  (threshold),
    .axisEn     (axisEn),
    .durLen     (durLen),
    .latLen     (latLen),
    .winLen     (winLen),
    .clearStrobe(clearStrobe),
    .strobe     (strobe),
    .status     (status),
    .singlePulse(singlePulse),
    .doublePulse(doublePulse),
    .singleFlag (singleFlag),
    .doubleFlag (doubleFlag),
    .firstAxis  (firstAxis)
  );

endmodule

// File: tb/shock_detect_bench.sv
`timescale 1ns/1ps
module shock_detect_bench;

  localparam int SW = 12;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] accelX = '0, accelY = '0, accelZ = '0;
  logic [SW-1:0] threshold = '0;
  logic [CW-1:0] durLen = '0, latLen = '0, winLen = '0;
  logic [2:0]    axisEn = '0;
  logic          suppressEn = 1'b0, singleEn = 1'b0, doubleEn = 1'b0, clearStrobe = 1'b0;
  logic          singlePulse, doublePulse, singleFlag, doubleFlag;
  logic [2:0]    firstAxis;

  int checks = 0;
  int errors = 0;
  logic [2:0] keptAxis;

  always #4 clk = ~clk;

  shock_detect #(.SAMPLE_W(SW), .CNT_W(CW)) u_shock_detect (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .accelX(accelX), .accelY(accelY), .accelZ(accelZ),
    .threshold(threshold), .durLen(durLen), .latLen(latLen), .winLen(winLen),
    .axisEn(axisEn), .suppressEn(suppressEn), .singleEn(singleEn), .doubleEn(doubleEn),
    .clearStrobe(clearStrobe), .singlePulse(singlePulse), .doublePulse(doublePulse),
    .singleFlag(singleFlag), .doubleFlag(doubleFlag), .firstAxis(firstAxis)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stepC(input int x, input int y, input int z, input logic clr);
    @(negedge clk);
    sampleValid = 1'b1;
    accelX = SW'(x); accelY = SW'(y); accelZ = SW'(z);
    clearStrobe = clr;
    @(posedge clk); #2;
    clearStrobe = 1'b0;
  endtask

  task automatic step(input int x, input int y, input int z);
    stepC(x, y, z, 1'b0);
  endtask

  task automatic gap(input int x);
    @(negedge clk);
    sampleValid = 1'b0;
    accelX = SW'(x); accelY = '0; accelZ = '0;
    @(posedge clk); #2;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic prep();
    threshold = 12'd100; durLen = 6'd3; latLen = 6'd2; winLen = 6'd4;
    axisEn = 3'b111; suppressEn = 1'b0; singleEn = 1'b1; doubleEn = 1'b1;
    quiet(10);
    @(negedge clk); clearStrobe = 1'b1; sampleValid = 1'b0;
    @(posedge clk); #2; clearStrobe = 1'b0;
  endtask

  task automatic testReset();
    chk("R10 reset singleFlag", singleFlag, 0);
    chk("R10 reset doubleFlag", doubleFlag, 0);
    chk("R9 reset firstAxis", firstAxis, 0);
    chk("R12 reset pulses", {singlePulse, doublePulse}, 0);
  endtask

  task automatic testSingle();
    prep(); doubleEn = 1'b0;
    step(200, 0, 0); step(200, 0, 0);
    chk("R2 no pulse mid spike", singlePulse, 0);
    step(0, 0, 0);
    chk("R2 single pulse", singlePulse, 1);
    chk("R10 single flag", singleFlag, 1);
    chk("R9 axis X", firstAxis, 1);
    step(0, 0, 0);
    chk("R12 pulse one cycle", singlePulse, 0);
  endtask

  task automatic testBoundary();
    prep(); doubleEn = 1'b0;
    step(100, -100, 100); step(0, 0, 0);
    chk("R1 equal not above", singleFlag, 0);
    step(0, -101, 0); step(0, -101, 0); step(0, -101, 0); step(0, 0, 0);
    chk("R2 exact duration qualifies", singlePulse, 1);
    chk("R9 axis Y", firstAxis, 2);
    prep(); doubleEn = 1'b0;
    step(0, 150, 0); step(0, 150, 0); step(0, 150, 0); step(0, 150, 0); step(0, 0, 0);
    chk("R2 too long rejected", singleFlag, 0);
    chk("R9 axis kept", firstAxis, 2);
    prep(); doubleEn = 1'b0; durLen = '0;
    step(0, 150, 0); step(0, 0, 0);
    chk("R2 zero duration rejects", singleFlag, 0);
  endtask

  task automatic testMostNeg();
    prep(); doubleEn = 1'b0; threshold = 12'd2047;
    step(2047, 0, 0); step(0, 0, 0);
    chk("R1 max positive not above", singleFlag, 0);
    step(-2048, -2048, 0); step(0, 0, 0);
    chk("R1 most negative above", singlePulse, 1);
    chk("R9 two axes at once", firstAxis, 3);
  endtask

  task automatic testDouble();
    prep();
    step(200, 0, 0); step(0, 0, 0);
    chk("R2 first shock flagged", singlePulse, 1);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(0, 300, 0); step(0, 300, 0);
    chk("R3 no double mid spike", doublePulse, 0);
    step(0, 0, 0);
    chk("R3 double pulse", doublePulse, 1);
    chk("R9 axis of second shock", firstAxis, 2);
    chk("R10 both flags", {singleFlag, doubleFlag}, 3);
  endtask

  task automatic patSuppress();
    step(200, 0, 0); step(0, 0, 0); step(200, 0, 0); step(0, 0, 0);
    step(0, 0, 0); step(200, 0, 0); step(0, 0, 0);
  endtask

  task automatic testSuppress();
    prep(); suppressEn = 1'b1;
    patSuppress(); quiet(8);
    chk("R4 suppress abandons", doubleFlag, 0);
    prep(); suppressEn = 1'b0;
    patSuppress(); quiet(1);
    chk("R4 no suppress tolerates gap spike", doubleFlag, 1);
  endtask

  task automatic testOpenSpike();
    prep();
    step(200, 0, 0); step(0, 0, 0); step(0, 0, 0); step(200, 0, 0); step(0, 0, 0);
    quiet(8);
    chk("R5 spike at window open", doubleFlag, 0);
  endtask

  task automatic testLongSecond();
    prep();
    step(200, 0, 0); quiet(3);
    for (int i = 0; i < 4; i++) step(0, 0, 300);
    step(0, 0, 0); quiet(4);
    chk("R6 long second spike", doubleFlag, 0);
  endtask

  task automatic testWindow();
    prep();
    step(200, 0, 0); quiet(6); step(0, 0, 400); step(0, 0, 0);
    chk("R3 spike on last window sample", doublePulse, 1);
    prep();
    step(200, 0, 0); quiet(7); step(0, 0, 400); step(0, 0, 0);
    chk("R3 window expired no double", doubleFlag, 0);
    chk("R3 late spike is new single", singlePulse, 1);
  endtask

  task automatic testZeroLat();
    prep(); latLen = '0;
    step(200, 0, 0); quiet(3); step(200, 0, 0); step(0, 0, 0);
    chk("R7 zero latency no double", doubleFlag, 0);
    chk("R7 second is single", singlePulse, 1);
    prep(); winLen = '0;
    step(200, 0, 0); quiet(3); step(200, 0, 0); step(0, 0, 0);
    chk("R7 zero window no double", doubleFlag, 0);
  endtask

  task automatic testAxisEn();
    prep(); doubleEn = 1'b0; axisEn = 3'b100;
    step(500, 500, 0); step(0, 0, 0);
    chk("R1 disabled axes ignored", singleFlag, 0);
    step(0, 0, -300); step(0, 0, 0);
    chk("R1 enabled Z", singlePulse, 1);
    chk("R9 axis Z", firstAxis, 4);
  endtask

  task automatic testEnables();
    prep(); singleEn = 1'b0;
    keptAxis = firstAxis;
    step(200, 0, 0); step(0, 0, 0);
    chk("R8 single disabled pulse", singlePulse, 0);
    chk("R8 status untouched", firstAxis, keptAxis);
    quiet(3); step(0, 300, 0); step(0, 0, 0);
    chk("R8 double still armed", doublePulse, 1);
    chk("R8 single flag stays low", singleFlag, 0);
    prep(); doubleEn = 1'b0;
    step(200, 0, 0); quiet(4); step(0, 300, 0); step(0, 0, 0); quiet(6);
    chk("R8 double disabled", doubleFlag, 0);
  endtask

  task automatic testClear();
    prep(); doubleEn = 1'b0;
    step(0, 200, 0); step(0, 0, 0);
    keptAxis = firstAxis;
    stepC(0, 0, 0, 1'b1);
    chk("R10 clear drops flag", singleFlag, 0);
    chk("R9 clear keeps axis", firstAxis, keptAxis);
    step(0, 200, 0); stepC(0, 0, 0, 1'b1);
    chk("R10 set beats clear", singleFlag, 1);
  endtask

  task automatic testValid();
    prep(); doubleEn = 1'b0;
    gap(500); gap(500); gap(500);
    chk("R11 invalid samples ignored", singleFlag, 0);
    step(200, 0, 0); gap(0); gap(0); gap(0);
    step(200, 0, 0); step(200, 0, 0); step(0, 0, 0);
    chk("R11 gaps not counted", singlePulse, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    testReset();
    testSingle();
    testBoundary();
    testMostNeg();
    testDouble();
    testSuppress();
    testOpenSpike();
    testLongSecond();
    testWindow();
    testZeroLat();
    testAxisEn();
    testEnables();
    testClear();
    testValid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule